// File: doc/BRIEF.md
# Large Transfer Block Splitter

This block sits between a transfer scheduler and an SDIO command engine. A single request names a total byte count, a block size and a direction. The block splits that length into two parts. The whole blocks go out together as one multi-block extended read/write command. Any bytes left over go out afterwards as a second extended command in byte mode. A serial restoring divider finds the quotient and the remainder, one quotient bit per cycle, so the block needs no wide combinational divider.

The scheduler supplies a one-cycle `start` pulse. It holds `busy` as the sign of whether the block will take a new request. Descriptors leave on a valid/ready stream. Once `desc_valid` rises, the descriptor fields stay frozen until the cycle in which `desc_ready` is also high. That cycle is the transfer. The receiver may hold `desc_ready` low for as long as it needs. After a descriptor is accepted, the block waits for a one-cycle `cmd_done` pulse that reports the command has completed. Only then does it offer the next descriptor or return to idle. Bus signalling, CRC and card responses are handled elsewhere.

Top module: `xfer_splitter`

## Requirements
- R1: A start pulse with `total_len` = 0 or `blk_size` = 0 makes `err` high for exactly the next cycle. No descriptor is offered and `busy` stays low.
- R2: When `total_len` >= `blk_size`, the first descriptor has `desc_blk_mode` = 1 (1 = block mode). It carries `desc_blk_cnt` = floor(`total_len`/`blk_size`) and `desc_byte_cnt` = `blk_size`, the bytes per block.
- R3: When `total_len` mod `blk_size` is nonzero, a byte-mode descriptor is offered. It has `desc_blk_mode` = 0, `desc_blk_cnt` = 0 and `desc_byte_cnt` = the remainder. It appears only after the block descriptor's `cmd_done`, when a block descriptor exists.
- R4: When `total_len` is an exact multiple of `blk_size`, no byte-mode descriptor is offered. `busy` falls after the block descriptor's `cmd_done`.
- R5: When `total_len` < `blk_size`, only the byte-mode descriptor is offered.
- R6: While `desc_valid` is high and `desc_ready` is low, `desc_valid` stays high and all descriptor fields stay unchanged.
- R7: After a descriptor is accepted, `desc_valid` stays low until `cmd_done` is pulsed. A `cmd_done` pulse while a descriptor is waiting for acceptance is ignored.
- R8: `busy` rises in the cycle after an accepted start and falls in the cycle after the last descriptor's `cmd_done`. A start pulse while `busy` is high is ignored, including one in the same cycle as that final `cmd_done`.
- R9: `desc_wr` equals the `dir` value captured at the accepted start (1 = write), on every descriptor of that transfer.
- R10: A 544-byte request with 64-byte blocks yields a block descriptor of 8 blocks, then a byte descriptor of 32 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request pulse |
| dir | input | 1 | Direction of the request, 1 = write |
| total_len | input | LEN_W | Total bytes to move |
| blk_size | input | BSZ_W | Bytes per block |
| desc_valid | output | 1 | Descriptor offered |
| desc_ready | input | 1 | Descriptor taken when high with desc_valid |
| desc_wr | output | 1 | Command direction, 1 = write |
| desc_blk_mode | output | 1 | 1 = block mode, 0 = byte mode |
| desc_blk_cnt | output | LEN_W | Block count (0 in byte mode) |
| desc_byte_cnt | output | BSZ_W | Block size in block mode, remainder in byte mode |
| cmd_done | input | 1 | One-cycle completion pulse of the accepted command |
| busy | output | 1 | A request is in progress |
| err | output | 1 | One-cycle flag for a rejected empty request |

## Verification
The collision of interest is a new start pulse in the same cycle as the completion pulse of the last descriptor. A one-cycle slip in the idle decision would let that start begin a fresh transfer. The bench provokes this on every fourth length of its sweep by raising `start` together with the final `cmd_done`. It judges the result by `busy` being low one cycle and two cycles later, with no descriptor appearing. A second overlap is a completion pulse that arrives while a descriptor is still waiting for acceptance. The bench sends one and requires the same descriptor, unchanged, to remain offered.

// File: rtl/xfer_split_pkg.sv
package xfer_split_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_DIV,
    S_BLK_OFFER,
    S_BLK_WAIT,
    S_BYT_OFFER,
    S_BYT_WAIT
  } split_state_e;

  localparam logic MODE_BLOCK = 1'b1;
  localparam logic MODE_BYTE  = 1'b0;
endpackage

// File: rtl/xfer_len_div.sv
module xfer_len_div #(
  parameter int LEN_W = 16,
  parameter int BSZ_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [LEN_W-1:0] dividend,
  input  logic [BSZ_W-1:0] divisor,
  output logic             done,
  output logic [LEN_W-1:0] quot,
  output logic [BSZ_W-1:0] rem
);
  localparam int CNT_W = $clog2(LEN_W + 1);
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(LEN_W - 1);

  logic             run_q;
  logic [CNT_W-1:0] step_q;
  logic [LEN_W-1:0] acc_q;   // dividend shifts out, quotient shifts in
  logic [BSZ_W-1:0] part_q;  // partial remainder
  logic [BSZ_W-1:0] dvs_q;

  logic [BSZ_W:0]   trial;
  logic             fits;
  logic [BSZ_W-1:0] diff;

  always_comb begin
    trial = {part_q, acc_q[LEN_W-1]};
    fits  = trial >= {1'b0, dvs_q};
    diff  = trial[BSZ_W-1:0] - dvs_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      step_q <= '0;
      acc_q  <= '0;
      part_q <= '0;
      dvs_q  <= '0;
      done   <= 1'b0;
    end else if (go) begin
      run_q  <= 1'b1;
      step_q <= '0;
      acc_q  <= dividend;
      part_q <= '0;
      dvs_q  <= divisor;
      done   <= 1'b0;
    end else if (run_q) begin
      acc_q  <= {acc_q[LEN_W-2:0], fits};
      part_q <= fits ? diff : trial[BSZ_W-1:0];
      step_q <= step_q + 1'b1;
      if (step_q == LAST_STEP) begin
        run_q <= 1'b0;
        done  <= 1'b1;
      end
    end else begin
      done <= 1'b0;
    end
  end

  assign quot = acc_q;
  assign rem  = part_q;
endmodule

// File: rtl/xfer_split_seq.sv
module xfer_split_seq
  import xfer_split_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int BSZ_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             dir,
  input  logic [LEN_W-1:0] total_len,
  input  logic [BSZ_W-1:0] blk_size,
  output logic             div_go,
  input  logic             div_done,
  input  logic [LEN_W-1:0] div_quot,
  input  logic [BSZ_W-1:0] div_rem,
  output logic             desc_valid,
  input  logic             desc_ready,
  output logic             desc_wr,
  output logic             desc_blk_mode,
  output logic [LEN_W-1:0] desc_blk_cnt,
  output logic [BSZ_W-1:0] desc_byte_cnt,
  input  logic             cmd_done,
  output logic             busy,
  output logic             err
);
  split_state_e     state_q;
  logic             wr_q;
  logic [BSZ_W-1:0] bsz_q;
  logic [LEN_W-1:0] quot_q;
  logic [BSZ_W-1:0] rem_q;
  logic             err_q;
  logic             req_bad;

  assign req_bad = (total_len == '0) || (blk_size == '0);
  assign div_go  = (state_q == S_IDLE) && start && !req_bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      wr_q    <= 1'b0;
      bsz_q   <= '0;
      quot_q  <= '0;
      rem_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q <= 1'b0;
      unique case (state_q)
        S_IDLE: begin
          if (start) begin
            if (req_bad) begin
              err_q <= 1'b1;
            end else begin
              wr_q    <= dir;
              bsz_q   <= blk_size;
              state_q <= S_DIV;
            end
          end
        end
        S_DIV: begin
          if (div_done) begin
            quot_q  <= div_quot;
            rem_q   <= div_rem;
            state_q <= (div_quot != '0) ? S_BLK_OFFER : S_BYT_OFFER;
          end
        end
        S_BLK_OFFER: if (desc_ready) state_q <= S_BLK_WAIT;
        S_BLK_WAIT: begin
          if (cmd_done) state_q <= (rem_q != '0) ? S_BYT_OFFER : S_IDLE;
        end
        S_BYT_OFFER: if (desc_ready) state_q <= S_BYT_WAIT;
        S_BYT_WAIT:  if (cmd_done) state_q <= S_IDLE;
        default:     state_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    desc_valid    = (state_q == S_BLK_OFFER) || (state_q == S_BYT_OFFER);
    desc_blk_mode = (state_q == S_BLK_OFFER) ? MODE_BLOCK : MODE_BYTE;
    desc_blk_cnt  = (state_q == S_BLK_OFFER) ? quot_q : '0;
    desc_byte_cnt = (state_q == S_BLK_OFFER) ? bsz_q : rem_q;
    desc_wr       = wr_q;
    busy          = (state_q != S_IDLE);
    err           = err_q;
  end
endmodule

// File: rtl/xfer_splitter.sv
module xfer_splitter #(
  parameter int LEN_W = 16,
  parameter int BSZ_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             dir,
  input  logic [LEN_W-1:0] total_len,
  input  logic [BSZ_W-1:0] blk_size,
  output logic             desc_valid,
  input  logic             desc_ready,
  output logic             desc_wr,
  output logic             desc_blk_mode,
  output logic [LEN_W-1:0] desc_blk_cnt,
  output logic [BSZ_W-1:0] desc_byte_cnt,
  input  logic             cmd_done,
  output logic             busy,
  output logic             err
);
  logic             div_go;
  logic             div_done;
  logic [LEN_W-1:0] div_quot;
  logic [BSZ_W-1:0] div_rem;

  xfer_len_div #(.LEN_W(LEN_W), .BSZ_W(BSZ_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (div_go),
    .dividend (total_len),
    .divisor  (blk_size),
    .done     (div_done),
    .quot     (div_quot),
    .rem      (div_rem)
  );

  xfer_split_seq #(.LEN_W(LEN_W), .BSZ_W(BSZ_W)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .dir           (dir),
    .total_len     (total_len),
    .blk_size      (blk_size),
    .div_go        (div_go),
    .div_done      (div_done),
    .div_quot      (div_quot),
    .div_rem       (div_rem),
    .desc_valid    (desc_valid),
    .desc_ready    (desc_ready),
    .desc_wr       (desc_wr),
    .desc_blk_mode (desc_blk_mode),
    .desc_blk_cnt  (desc_blk_cnt),
    .desc_byte_cnt (desc_byte_cnt),
    .cmd_done      (cmd_done),
    .busy          (busy),
    .err           (err)
  );
endmodule

// File: rtl/xfer_splitter_chk.sv
module xfer_splitter_chk #(
  parameter int LEN_W = 16,
  parameter int BSZ_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             desc_valid,
  input logic             desc_ready,
  input logic             desc_wr,
  input logic             desc_blk_mode,
  input logic [LEN_W-1:0] desc_blk_cnt,
  input logic [BSZ_W-1:0] desc_byte_cnt,
  input logic             cmd_done,
  input logic             busy,
  input logic             err
);
  // R6
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid && !desc_ready |=> desc_valid && $stable(desc_wr) &&
      $stable(desc_blk_mode) && $stable(desc_blk_cnt) && $stable(desc_byte_cnt));

  // R7
  no_reoffer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid && desc_ready |=> !desc_valid);

  // R8
  valid_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid |-> busy);

  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !cmd_done |=> busy);

  // R1
  err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !busy && !desc_valid);

  // R2
  blk_desc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid && desc_blk_mode |-> (desc_blk_cnt != '0) && (desc_byte_cnt != '0));

  // R3
  byte_desc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid && !desc_blk_mode |-> (desc_blk_cnt == '0) && (desc_byte_cnt != '0));
endmodule

bind xfer_splitter xfer_splitter_chk #(.LEN_W(LEN_W), .BSZ_W(BSZ_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .desc_valid    (desc_valid),
  .desc_ready    (desc_ready),
  .desc_wr       (desc_wr),
  .desc_blk_mode (desc_blk_mode),
  .desc_blk_cnt  (desc_blk_cnt),
  .desc_byte_cnt (desc_byte_cnt),
  .cmd_done      (cmd_done),
  .busy          (busy),
  .err           (err)
);

// File: tb/tb_xfer_splitter.sv
`timescale 1ns/1ps
module tb_xfer_splitter;
  localparam int LEN_W = 10;
  localparam int BSZ_W = 7;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic             dir = 1'b0;
  logic [LEN_W-1:0] total_len = '0;
  logic [BSZ_W-1:0] blk_size = '0;
  logic             desc_valid;
  logic             desc_ready = 1'b0;
  logic             desc_wr;
  logic             desc_blk_mode;
  logic [LEN_W-1:0] desc_blk_cnt;
  logic [BSZ_W-1:0] desc_byte_cnt;
  logic             cmd_done = 1'b0;
  logic             busy;
  logic             err;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  xfer_splitter #(.LEN_W(LEN_W), .BSZ_W(BSZ_W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .dir(dir),
    .total_len(total_len), .blk_size(blk_size),
    .desc_valid(desc_valid), .desc_ready(desc_ready), .desc_wr(desc_wr),
    .desc_blk_mode(desc_blk_mode), .desc_blk_cnt(desc_blk_cnt),
    .desc_byte_cnt(desc_byte_cnt), .cmd_done(cmd_done),
    .busy(busy), .err(err)
  );

  task automatic check_eq(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_valid(input string tag);
    int t = 0;
    while (!desc_valid && t < 200) begin
      @(negedge clk);
      t++;
    end
    check_eq({tag, " descriptor offered"}, int'(desc_valid), 1);
  endtask

  // Serve one descriptor as the downstream engine would.
  task automatic serve(input string tag, input bit mode, input int blks,
                       input int bytes, input bit wr, input bit last,
                       input string last_tag, input int hold, input int gap,
                       input bit coinc);
    wait_valid(tag);
    check_eq({tag, " mode"}, int'(desc_blk_mode), int'(mode));
    check_eq({tag, " block count"}, int'(desc_blk_cnt), blks);
    check_eq({tag, " byte count"}, int'(desc_byte_cnt), bytes);
    check_eq("R9 direction", int'(desc_wr), int'(wr));
    for (int i = 0; i < hold; i++) begin
      if (i == 0) cmd_done = 1'b1;     // R7: ignored while offering
      @(negedge clk);
      cmd_done = 1'b0;
      check_eq("R6 valid held", int'(desc_valid), 1);
      check_eq("R6 byte count held", int'(desc_byte_cnt), bytes);
      check_eq("R7 early done ignored", int'(desc_blk_cnt), blks);
    end
    desc_ready = 1'b1;
    @(negedge clk);
    desc_ready = 1'b0;
    check_eq("R7 valid dropped after accept", int'(desc_valid), 0);
    for (int i = 0; i < gap; i++) begin
      @(negedge clk);
      check_eq("R7 no offer before done", int'(desc_valid), 0);
    end
    cmd_done = 1'b1;
    if (coinc) begin
      start = 1'b1;
      total_len = LEN_W'(5);
      blk_size = BSZ_W'(1);
    end
    @(negedge clk);
    cmd_done = 1'b0;
    start = 1'b0;
    if (last) begin
      check_eq({last_tag, " busy low after last done"}, int'(busy), 0);
      @(negedge clk);
      check_eq("R8 busy stays low, start ignored", int'(busy), 0);
      check_eq("R8 no descriptor after end", int'(desc_valid), 0);
    end else begin
      check_eq("R8 busy between descriptors", int'(busy), 1);
    end
  endtask

  task automatic run_xfer(input int len, input int bsz, input bit wr,
                          input int hold, input int gap, input bit coinc,
                          input string pfx);
    int q = len / bsz;
    int r = len % bsz;
    string ltag = (r == 0) ? "R4" : ((q == 0) ? "R5" : "R3");
    start = 1'b1; dir = wr;
    total_len = LEN_W'(len); blk_size = BSZ_W'(bsz);
    @(negedge clk);
    start = 1'b0;
    check_eq("R8 busy after start", int'(busy), 1);
    // R8: a start while busy, with an empty length, must change nothing
    start = 1'b1; dir = ~wr; total_len = '0;
    @(negedge clk);
    start = 1'b0;
    check_eq("R8 start while busy ignored", int'(err), 0);
    if (q != 0)
      serve((pfx != "") ? pfx : "R2", 1'b1, q, bsz, wr, (r == 0), ltag, hold, gap, coinc);
    if (r != 0)
      serve((pfx != "") ? pfx : "R3", 1'b0, 0, r, wr, 1'b1, ltag, hold, gap, coinc);
  endtask

  task automatic run_err(input int len, input int bsz);
    start = 1'b1; total_len = LEN_W'(len); blk_size = BSZ_W'(bsz);
    @(negedge clk);
    start = 1'b0;
    check_eq("R1 err pulse", int'(err), 1);
    check_eq("R1 busy low", int'(busy), 0);
    check_eq("R1 no descriptor", int'(desc_valid), 0);
    @(negedge clk);
    check_eq("R1 err one cycle", int'(err), 0);
    check_eq("R1 still idle", int'(busy), 0);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    summary();
    $finish;
  end

  initial begin
    int sizes[4] = '{1, 5, 64, 127};
    repeat (3) @(negedge clk);
    check_eq("reset busy", int'(busy), 0);
    check_eq("reset valid", int'(desc_valid), 0);
    check_eq("reset err", int'(err), 0);
    rst_n = 1'b1;
    @(negedge clk);

    run_err(0, 64);
    run_err(37, 0);
    run_xfer(544, 64, 1'b1, 2, 1, 1'b1, "R10");
    run_xfer(544, 64, 1'b0, 0, 0, 1'b0, "R10");

    foreach (sizes[k]) begin
      for (int len = 0; len < 512; len++) begin
        if (len == 0) run_err(len, sizes[k]);
        else run_xfer(len, sizes[k], len[0], len % 3, len % 2, (len % 4) == 0, "");
      end
    end
    summary();
    $finish;
  end
endmodule